// File: doc/BRIEF.md
# Port-Mapped I/O Decoder with Output Latch and Input Port

This block gives an 8-bit CPU bus a separate I/O address space. It watches the 16-bit address, the write data, an active-low I/O-request strobe, an active-low memory-request strobe and active-low read and write strobes. From the low address byte it forms one of up to 256 input-port selects for qualified I/O reads and one of up to 256 output-port selects for qualified I/O writes. The upper address byte takes no part in I/O selection.

Two ports are implemented at fixed numbers. Port 03h is an 8-bit output latch that captures the write data once per write strobe. Port 02h is an 8-bit input port that passes external data onto the returned read bus. A data-drive flag marks the cycle in which that data is valid, and otherwise the read bus idles at all ones. Any cycle with the memory request asserted leaves both ports, the selects and the drive flag untouched, whatever its address.

All outputs are registered. An effect of the bus inputs sampled at one rising clock edge shows on the outputs right after that edge.

Top module: `io_port_block`

## Requirements
- R1: While reset is high and after it is released, out_q is 00h, bus_rdata is FFh, rdata_drive is 0 and every bit of in_sel and out_sel is 0.
- R2: When iorq_n=0, rd_n=0 and mreq_n=1 at an edge, in_sel after that edge has exactly bit N set, where N is bus_addr[7:0], whatever bus_addr[15:8] holds.
- R3: When iorq_n=0, wr_n=0, rd_n=1 and mreq_n=1 at an edge, out_sel after that edge has exactly bit N set, where N is bus_addr[7:0], whatever bus_addr[15:8] holds.
- R4: A select vector is all zeros after any edge without its qualifying strobe pair. A read has priority when rd_n and wr_n are both low.
- R5: An I/O write to port 03h, with any upper address byte, loads bus_wdata into out_q, visible right after the capturing edge.
- R6: A write strobe to port 03h held over several edges captures only at the first such edge. Data changes while it stays held do not reach out_q. A new strobe after a release captures again.
- R7: An I/O read of port 02h sets rdata_drive to 1 and bus_rdata to the ext_in value sampled at that edge.
- R8: After any edge that is not an I/O read of port 02h, rdata_drive is 0 and bus_rdata is FFh.
- R9: With mreq_n=0, even with bus_addr[7:0] at 02h or 03h and iorq_n, rd_n or wr_n low, out_q keeps its value, rdata_drive stays 0 and both select vectors stay zero.
- R10: out_q keeps its value through writes to other ports and through reads of any port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 16 | CPU address bus; bits 7:0 carry the port number |
| bus_wdata | input | 8 | CPU write data |
| iorq_n | input | 1 | I/O request, active low |
| mreq_n | input | 1 | Memory request, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| ext_in | input | 8 | External data for the input port at 02h |
| bus_rdata | output | 8 | Read data returned to the CPU; FFh when not driving |
| rdata_drive | output | 1 | High in the cycle the input port drives bus_rdata |
| in_sel | output | 256 | One-hot input-port selects |
| out_sel | output | 256 | One-hot output-port selects |
| out_q | output | 8 | Contents of the output latch at port 03h |

## Verification
The bench aims at a write strobe to 03h that is held while its data changes. A latch that loads on the level instead of the edge would follow the new data. It issues memory cycles at addresses whose low byte is 02h or 03h with the I/O strobes also low. A decoder that ignores the memory request would load the latch or raise the drive flag. It uses non-zero upper address bytes, which a decoder that compares the full address would miss. It also reads unimplemented ports, which a wrong mux would answer with stale input data instead of FFh.

// File: rtl/io_map_pkg.sv
package io_map_pkg;

  typedef enum logic [1:0] {
    CYC_IDLE  = 2'd0,
    CYC_IO_RD = 2'd1,
    CYC_IO_WR = 2'd2,
    CYC_MEM   = 2'd3
  } bus_cycle_e;

  // A memory request overrides everything; a read wins over a write.
  function automatic bus_cycle_e classify_cycle(input logic iorq_n,
                                                input logic mreq_n,
                                                input logic rd_n,
                                                input logic wr_n);
    bus_cycle_e k;
    if (!mreq_n)               k = CYC_MEM;
    else if (!iorq_n && !rd_n) k = CYC_IO_RD;
    else if (!iorq_n && !wr_n) k = CYC_IO_WR;
    else                       k = CYC_IDLE;
    return k;
  endfunction

endpackage

// File: rtl/io_sel_decode.sv
module io_sel_decode #(
  parameter int PORT_W = 8,
  localparam int NPORTS = 1 << PORT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [PORT_W-1:0] port_no,
  output logic [NPORTS-1:0] sel
);

  for (genvar i = 0; i < NPORTS; i++) begin : g_sel
    always_ff @(posedge clk) begin
      if (rst) sel[i] <= 1'b0;
      else     sel[i] <= en && (port_no == PORT_W'(i));
    end
  end

endmodule

// File: rtl/io_out_latch.sv
module io_out_latch #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hit,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] q
);

  logic hit_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_prev <= 1'b0;
      q        <= '0;
    end else begin
      hit_prev <= hit;
      if (hit && !hit_prev) q <= d;
    end
  end

endmodule

// File: rtl/io_in_port.sv
module io_in_port #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hit,
  input  logic [DATA_W-1:0] ext,
  output logic [DATA_W-1:0] rdata,
  output logic              drive
);

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '1;
      drive <= 1'b0;
    end else begin
      rdata <= hit ? ext : '1;
      drive <= hit;
    end
  end

endmodule

// File: rtl/io_port_block.sv
module io_port_block #(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int PORT_W   = 8,
  parameter int OUT_PORT = 3,
  parameter int IN_PORT  = 2,
  localparam int NPORTS  = 1 << PORT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              iorq_n,
  input  logic              mreq_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [DATA_W-1:0] ext_in,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              rdata_drive,
  output logic [NPORTS-1:0] in_sel,
  output logic [NPORTS-1:0] out_sel,
  output logic [DATA_W-1:0] out_q
);
  import io_map_pkg::*;

  bus_cycle_e        kind;
  logic [PORT_W-1:0] port_no;
  logic              rd_en, wr_en, out_hit, in_hit;

  always_comb begin
    kind    = classify_cycle(iorq_n, mreq_n, rd_n, wr_n);
    port_no = bus_addr[PORT_W-1:0];
    rd_en   = (kind == CYC_IO_RD);
    wr_en   = (kind == CYC_IO_WR);
    out_hit = wr_en && (port_no == PORT_W'(OUT_PORT));
    in_hit  = rd_en && (port_no == PORT_W'(IN_PORT));
  end

  io_sel_decode #(.PORT_W(PORT_W)) u_rd_dec (
    .clk(clk), .rst(rst), .en(rd_en), .port_no(port_no), .sel(in_sel)
  );

  io_sel_decode #(.PORT_W(PORT_W)) u_wr_dec (
    .clk(clk), .rst(rst), .en(wr_en), .port_no(port_no), .sel(out_sel)
  );

  io_out_latch #(.DATA_W(DATA_W)) u_latch (
    .clk(clk), .rst(rst), .hit(out_hit), .d(bus_wdata), .q(out_q)
  );

  io_in_port #(.DATA_W(DATA_W)) u_inp (
    .clk(clk), .rst(rst), .hit(in_hit), .ext(ext_in),
    .rdata(bus_rdata), .drive(rdata_drive)
  );

endmodule

// File: rtl/io_port_block_chk.sv
module io_port_block_chk #(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int PORT_W   = 8,
  parameter int OUT_PORT = 3,
  parameter int IN_PORT  = 2,
  localparam int NPORTS  = 1 << PORT_W
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              iorq_n,
  input logic              mreq_n,
  input logic              rd_n,
  input logic              wr_n,
  input logic [DATA_W-1:0] ext_in,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              rdata_drive,
  input logic [NPORTS-1:0] in_sel,
  input logic [NPORTS-1:0] out_sel,
  input logic [DATA_W-1:0] out_q
);

  logic [1:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst) since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  logic wr03;
  assign wr03 = !iorq_n && !wr_n && rd_n && mreq_n &&
                (bus_addr[PORT_W-1:0] == PORT_W'(OUT_PORT));

  a_r4_sel_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(in_sel) && $onehot0(out_sel));

  a_r5_latch_cause: assert property (@(posedge clk) disable iff (rst)
    (since_rst != 2'd0) && !$stable(out_q) |-> $past(wr03));

  a_r6_held_once: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 2'd2) && $past(wr03) && $past(wr03, 2) |-> $stable(out_q));

  a_r7_drive_data: assert property (@(posedge clk) disable iff (rst)
    (since_rst != 2'd0) && rdata_drive |->
      $past(!iorq_n && !rd_n && mreq_n &&
            bus_addr[PORT_W-1:0] == PORT_W'(IN_PORT)) &&
      bus_rdata == $past(ext_in));

  a_r8_idle_ones: assert property (@(posedge clk) disable iff (rst)
    !rdata_drive |-> bus_rdata == '1);

  a_r9_mem_quiet: assert property (@(posedge clk) disable iff (rst)
    (since_rst != 2'd0) && $past(!mreq_n) |->
      $stable(out_q) && !rdata_drive && in_sel == '0 && out_sel == '0);

endmodule

bind io_port_block io_port_block_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PORT_W(PORT_W),
  .OUT_PORT(OUT_PORT), .IN_PORT(IN_PORT)
) u_chk (.*);

// File: tb/io_port_block_test.sv
module io_port_block_test;
  localparam int NP = 256;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        iorq_n = 1'b1, mreq_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [7:0]  ext_in = '0;
  logic [7:0]  bus_rdata;
  logic        rdata_drive;
  logic [NP-1:0] in_sel, out_sel;
  logic [7:0]  out_q;

  int checks = 0;
  int errors = 0;
  logic [7:0] m_latch = 8'h00;
  logic       m_prev  = 1'b0;

  always #10 clk = ~clk;

  io_port_block uut (.*);

  task automatic chk(input bit ok, input string tag, input logic [NP-1:0] act,
                     input logic [NP-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Drive one bus cycle at the falling edge, check just after the next rising edge.
  task automatic step(input logic [15:0] a, input logic [7:0] wd, input logic io,
                      input logic mr, input logic r, input logic w, input logic [7:0] ex);
    logic rdq, wrq, hit03;
    logic [NP-1:0] e_in, e_out;
    logic [7:0] e_rd;
    @(negedge clk);
    bus_addr = a; bus_wdata = wd; iorq_n = io; mreq_n = mr;
    rd_n = r; wr_n = w; ext_in = ex;
    rdq = mr && !io && !r;
    wrq = mr && !io && !w && r;
    e_in = '0; e_out = '0;
    if (rdq) e_in[a[7:0]] = 1'b1;
    if (wrq) e_out[a[7:0]] = 1'b1;
    hit03 = wrq && (a[7:0] == 8'h03);
    if (hit03 && !m_prev) m_latch = wd;
    m_prev = hit03;
    e_rd = (rdq && a[7:0] == 8'h02) ? ex : 8'hFF;
    @(posedge clk); #2;
    chk(in_sel == e_in, rdq ? "R2 in_sel" : "R4 in_sel", in_sel, e_in);
    chk(out_sel == e_out, wrq ? "R3 out_sel" : "R4 out_sel", out_sel, e_out);
    chk(bus_rdata == e_rd && rdata_drive == (rdq && a[7:0] == 8'h02),
        (rdq && a[7:0] == 8'h02) ? "R7 read" : "R8 read",
        {bus_rdata, 7'b0, rdata_drive}, {e_rd, 7'b0, (rdq && a[7:0] == 8'h02)});
    chk(out_q == m_latch, hit03 ? "R5 latch" : "R10 latch", out_q, m_latch);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int unused;
    unused = $urandom(32'd1234);
    repeat (3) @(posedge clk);
    #2;
    // R1 reset state
    chk(out_q == 8'h00 && bus_rdata == 8'hFF && !rdata_drive &&
        in_sel == '0 && out_sel == '0, "R1 reset",
        {out_q, bus_rdata, 7'b0, rdata_drive}, {8'h00, 8'hFF, 8'h00});
    @(negedge clk); rst = 1'b0;
    step(16'h0000, 8'h00, 1, 1, 1, 1, 8'h00);
    // R5 write with non-zero upper byte
    step(16'hAB03, 8'h5A, 0, 1, 1, 0, 8'h00);
    // R6 held strobe, data changes: no recapture
    step(16'hAB03, 8'hC3, 0, 1, 1, 0, 8'h00);
    step(16'h1203, 8'h77, 0, 1, 1, 0, 8'h00);
    step(16'h0000, 8'h00, 1, 1, 1, 1, 8'h00);
    step(16'h0003, 8'h3C, 0, 1, 1, 0, 8'h00);
    // R9 memory cycles at 02h/03h with I/O strobes low
    step(16'h0003, 8'hEE, 0, 0, 1, 0, 8'h11);
    step(16'h7702, 8'hEE, 0, 0, 0, 1, 8'h22);
    step(16'h0003, 8'h99, 1, 0, 1, 0, 8'h00);
    // R7 read of port 02h, R8 read of other ports
    step(16'hFF02, 8'h00, 0, 1, 0, 1, 8'hA5);
    step(16'h0005, 8'h00, 0, 1, 0, 1, 8'hA5);
    step(16'h00FF, 8'h00, 0, 1, 0, 1, 8'h6B);
    // R4 both strobes low: read wins; R10 latch unaffected
    step(16'h0003, 8'h01, 0, 1, 0, 0, 8'h4D);
    step(16'h0000, 8'h00, 1, 1, 1, 1, 8'h00);
    for (int n = 0; n < 600; n++) begin
      logic [15:0] a;
      logic [2:0] pick;
      logic io, mr, r, w;
      a = 16'($urandom);
      pick = 3'($urandom);
      if (pick < 3'd3) a[7:0] = 8'h03;
      else if (pick < 3'd5) a[7:0] = 8'h02;
      mr = ($urandom % 4) != 0;
      io = ($urandom % 3) == 0;
      r  = ($urandom % 2) == 0;
      w  = r ? (($urandom % 3) == 0) : 1'b1;
      step(a, 8'($urandom), io, mr, r, w, 8'($urandom));
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule